// File: doc/BRIEF.md
# PCM Frame Sync Generator and Detector

This block creates or recognises the frame synchronisation pulse of a serial PCM voice bus. It runs entirely on the bus bit clock and keeps a bit index inside the current frame. In the master role it drives the sync line and repeats a pulse once every `frame_bits` bit clocks. `frame_bits` is the bit-clock rate divided by the audio frame rate; at an 8 kHz frame rate a 2048 kHz bit clock gives 256. In the slave role it leaves the sync line undriven, watches the incoming sync, and aligns its own bit index to the frames it detects. In both roles it raises `frame_start` for the one bit period that carries the first bit of slot 0.

There are two sync formats. In the short format the pulse is one bit period wide. It sits in the bit just before slot 0 starts: a receiver sees it high on a falling edge, and slot 0 begins at the next rising edge. In the long format the pulse is three bit periods wide and begins with the first bit of slot 0. A slave acts only on a low-to-high change of the sync level, and it takes that sample on the falling edge of the bit clock. Between pulses it keeps counting frames on its own. Any new pulse realigns the count, even one at an unexpected bit position.

The controller has four states. `ST_IDLE` is the reset state. `ST_MASTER` counts bits and drives sync. `ST_HUNT` is a slave that has not yet seen a pulse. `ST_TRACK` is a slave that is aligned and counting. The transitions are:
- Any state goes to `ST_MASTER` when the role input selects master. When this happens from another state, the index is cleared to 0.
- In the slave role, a detected sync edge moves any state to `ST_TRACK` and loads the index.
- In the slave role with no edge, `ST_TRACK` stays where it is and advances the index.
- In the slave role with no edge, `ST_IDLE`, `ST_MASTER` and `ST_HUNT` go to `ST_HUNT` with the index at 0.

Top module: `pcm_fsync`

## Requirements
- R1: While reset is asserted, `sync_out`, `sync_oe` and `frame_start` are all 0.
- R2: `sync_oe` is 1 only in the master role. In the slave role `sync_oe` and `sync_out` are both 0, starting one clock after the role input changes.
- R3: In master mode, `frame_start` is 1 in the first bit period after master mode is entered. It then repeats exactly every `frame_bits` bit clocks and is 0 in every other bit period.
- R4: In master short format, `sync_out` is 1 only in the bit period just before each `frame_start` bit, which is index `frame_bits`-1. The pulse is exactly one bit wide in each frame.
- R5: In master long format, `sync_out` is 1 in bit indices 0, 1 and 2, so it is 3 bits wide and begins in the `frame_start` bit.
- R6: In slave short format, when sync is sampled high on a falling edge after being low, the bit that begins at the next rising edge is slot 0 and `frame_start` is 1 for that bit.
- R7: In slave long format, a rising sync edge marks the bit in which it was sampled as index 0. `frame_start` follows `frame_bits` bits later, and is not given for the bit already under way.
- R8: In slave mode, once aligned, `frame_start` keeps repeating every `frame_bits` bits with no further sync pulses.
- R9: In slave mode, a sync pulse at an unexpected bit position realigns the index. Later strobes follow the new pulse, and the old phase gives no strobe.
- R10: In slave mode, a sync level held high causes only one alignment. Only a low-to-high change counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| long_fmt | input | 1 | 1 = long three-bit sync, 0 = short one-bit sync |
| is_master | input | 1 | 1 = generate sync, 0 = detect sync |
| frame_bits | input | CNT_W (10) | Bit clocks per frame; must be at least 4 |
| sync_in | input | 1 | Sync line as seen at the pin |
| sync_out | output | 1 | Sync level to drive onto the pin |
| sync_oe | output | 1 | Drive enable for the sync pin |
| frame_start | output | 1 | One bit-period strobe on the first bit of slot 0 |

## Verification
The assertions check the following on every clock:
- A slave never drives a sync level.
- A short master pulse is always followed directly by the frame strobe.
- A long master pulse is always high in the strobe bit.
- A master strobe never lasts two bits.
- A detected slave edge leads to a strobe in the next bit in short format, and to no strobe in the next bit in long format.
- The edge detector never fires twice in a row.

Only the bench scenarios can show that whole frames work as required:
- The master repeats at the right period for several frame lengths.
- The pulse count in each frame is right.
- A slave keeps its phase with no further pulses.
- A displaced pulse moves later strobes and removes the old ones.
- A stuck-high line aligns the slave only once.

// File: rtl/pcm_fsync_pkg.sv
package pcm_fsync_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Controller states
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_MASTER,
        ST_HUNT,
        ST_TRACK
    } fs_state_e;

    // Width of the long sync pulse in bit periods
    localparam int unsigned LONG_WIDTH = 3;
    // Index assigned to the bit that follows a long-format detection
    localparam int unsigned LONG_LOAD  = 1;
endpackage

// File: rtl/pcm_fsync_sampler.sv
module pcm_fsync_sampler (
    input  logic bclk,
    input  logic rst_n,
    input  logic sync_in,
    output logic edge_seen
);
    timeunit 1ns;
    timeprecision 1ps;

    logic cur_q;
    logic prev_q;

    // Sync is sampled on the falling edge, mid-bit
    always_ff @(negedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            cur_q  <= sync_in;
            prev_q <= cur_q;
        end
    end

    // Only a low-to-high change counts
    assign edge_seen = cur_q & ~prev_q;

    AST_EDGE_ONESHOT: assert property (@(negedge bclk) disable iff (!rst_n)
        edge_seen |=> !edge_seen); // R10
endmodule

// File: rtl/pcm_fsync_counter.sv
module pcm_fsync_counter #(
    parameter int unsigned W = 10
) (
    input  logic         bclk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         adv,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [W-1:0] ONE = W'(1);

    logic [W-1:0] cnt_q;
    logic         at_end;

    // Wrap at or beyond the last index so a shrinking limit still wraps
    assign at_end = (cnt_q >= (lim - ONE));

    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (adv) begin
            cnt_q <= at_end ? '0 : cnt_q + ONE;
        end
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/pcm_fsync.sv
module pcm_fsync #(
    parameter int unsigned CNT_W = 10
) (
    input  logic             bclk,
    input  logic             rst_n,
    input  logic             long_fmt,
    input  logic             is_master,
    input  logic [CNT_W-1:0] frame_bits,
    input  logic             sync_in,
    output logic             sync_out,
    output logic             sync_oe,
    output logic             frame_start
);
    timeunit 1ns;
    timeprecision 1ps;
    import pcm_fsync_pkg::*;

    localparam logic [CNT_W-1:0] IDX_ZERO  = '0;
    localparam logic [CNT_W-1:0] IDX_ONE   = CNT_W'(1);
    localparam logic [CNT_W-1:0] LONG_END  = CNT_W'(LONG_WIDTH);
    localparam logic [CNT_W-1:0] LONG_SEED = CNT_W'(LONG_LOAD);

    fs_state_e        state_q;
    fs_state_e        state_d;
    logic             edge_seen;
    logic             cnt_clr;
    logic             cnt_load;
    logic             cnt_adv;
    logic [CNT_W-1:0] seed;
    logic [CNT_W-1:0] idx;

    pcm_fsync_sampler u_sampler (
        .bclk      (bclk),
        .rst_n     (rst_n),
        .sync_in   (sync_in),
        .edge_seen (edge_seen)
    );

    pcm_fsync_counter #(.W(CNT_W)) u_counter (
        .bclk     (bclk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .load     (cnt_load),
        .load_val (seed),
        .adv      (cnt_adv),
        .lim      (frame_bits),
        .cnt      (idx)
    );

    // Short: the next bit is slot 0. Long: the sampled bit was slot 0.
    assign seed = long_fmt ? LONG_SEED : IDX_ZERO;

    // State register
    always_ff @(posedge bclk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_load = 1'b0;
        cnt_adv  = 1'b0;
        if (is_master) begin
            if (state_q != ST_MASTER) begin
                state_d = ST_MASTER;
                cnt_clr = 1'b1;
            end else begin
                cnt_adv = 1'b1;
            end
        end else if (edge_seen) begin
            state_d  = ST_TRACK;
            cnt_load = 1'b1;
        end else begin
            unique case (state_q)
                ST_TRACK: cnt_adv = 1'b1;
                ST_IDLE, ST_MASTER, ST_HUNT: begin
                    state_d = ST_HUNT;
                    cnt_clr = 1'b1;
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sync_oe     = 1'b0;
        sync_out    = 1'b0;
        frame_start = 1'b0;
        unique case (state_q)
            ST_MASTER: begin
                sync_oe     = 1'b1;
                frame_start = (idx == IDX_ZERO);
                sync_out    = long_fmt ? (idx < LONG_END)
                                       : (idx == (frame_bits - IDX_ONE));
            end
            ST_TRACK: frame_start = (idx == IDX_ZERO);
            ST_IDLE, ST_HUNT: frame_start = 1'b0;
            default: frame_start = 1'b0;
        endcase
    end

    AST_SLAVE_QUIET: assert property (@(posedge bclk) disable iff (!rst_n)
        !sync_oe |-> !sync_out); // R2
    AST_STROBE_SINGLE: assert property (@(posedge bclk) disable iff (!rst_n)
        (frame_start && sync_oe && is_master && frame_bits > IDX_ONE) |=> !frame_start); // R3
    AST_SHORT_LEADS: assert property (@(posedge bclk) disable iff (!rst_n)
        (sync_oe && sync_out && !long_fmt) |=> (frame_start || !sync_oe)); // R4
    AST_LONG_OPENS: assert property (@(posedge bclk) disable iff (!rst_n)
        (sync_oe && long_fmt && frame_start) |-> sync_out); // R5
    AST_SHORT_LOCK: assert property (@(posedge bclk) disable iff (!rst_n)
        (!is_master && !long_fmt && edge_seen) |=> frame_start); // R6
    AST_LONG_LOCK: assert property (@(posedge bclk) disable iff (!rst_n)
        (!is_master && long_fmt && edge_seen) |=> !frame_start); // R7
endmodule

// File: tb/pcm_fsync_test.sv
module pcm_fsync_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = 10;
    localparam int VEC_N = 4;
    // Master stimulus table: format, frame length, expected sync bits per frame
    localparam int V_LONG [VEC_N] = '{0, 1, 0, 1};
    localparam int V_BITS [VEC_N] = '{8, 8, 32, 4};
    localparam int V_HIGH [VEC_N] = '{1, 3, 1, 3};

    logic             bclk = 1'b0;
    logic             rst_n = 1'b0;
    logic             long_fmt = 1'b0;
    logic             is_master = 1'b0;
    logic [CNT_W-1:0] frame_bits = 10'd8;
    logic             sync_in = 1'b0;
    logic             sync_out;
    logic             sync_oe;
    logic             frame_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    pcm_fsync #(.CNT_W(CNT_W)) uut (
        .bclk        (bclk),
        .rst_n       (rst_n),
        .long_fmt    (long_fmt),
        .is_master   (is_master),
        .frame_bits  (frame_bits),
        .sync_in     (sync_in),
        .sync_out    (sync_out),
        .sync_oe     (sync_oe),
        .frame_start (frame_start)
    );

    always #2 bclk = ~bclk;

    task automatic step;
        @(posedge bclk);
        #1;
    endtask

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
        end
    endtask

    task automatic chk_int(input int act, input int exp, input string tag, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Reset, check R1, release; returns at bit 0 after the first active edge
    task automatic do_reset(input logic m, input logic lf, input int n);
        rst_n      = 1'b0;
        is_master  = m;
        long_fmt   = lf;
        frame_bits = CNT_W'(n);
        sync_in    = 1'b0;
        step;
        step;
        chk(sync_out, 1'b0, "R1", "sync_out in reset");
        chk(sync_oe, 1'b0, "R1", "sync_oe in reset");
        chk(frame_start, 1'b0, "R1", "frame_start in reset");
        rst_n = 1'b1;
        step;
    endtask

    // Slave run: pulses at base + k*n (+shift from frame shift_frame on), npulse of them
    task automatic run_slave(input logic lf, input int n, input int total, input int npulse,
                             input int shift_frame, input int shift, input string tag);
        int lp;
        int w;
        int base;
        int off;
        lp   = -1;
        w    = lf ? 3 : 1;
        base = lf ? 0 : n - 1;
        off  = lf ? 0 : 1;
        do_reset(1'b0, lf, n);
        for (int g = 0; g < total; g++) begin
            logic hi;
            logic exp_fs;
            exp_fs = (lp >= 0) && (g > lp) && (((g - lp - off) % n) == 0);
            chk(frame_start, exp_fs, tag, $sformatf("frame_start bit %0d", g));
            chk(sync_oe, 1'b0, "R2", "slave sync_oe");
            chk(sync_out, 1'b0, "R2", "slave sync_out");
            hi = 1'b0;
            for (int k = 0; k < npulse; k++) begin
                int s;
                s = base + k * n + ((k >= shift_frame) ? shift : 0);
                if (g == s) lp = g;
                if (g >= s && g < s + w) hi = 1'b1;
            end
            sync_in = hi;
            step;
        end
        sync_in = 1'b0;
    endtask

    initial begin
        // Vector table: master runs
        for (int v = 0; v < VEC_N; v++) begin
            int n;
            int hi_cnt;
            string tag;
            n      = V_BITS[v];
            hi_cnt = 0;
            tag    = (V_LONG[v] != 0) ? "R5" : "R4";
            do_reset(1'b1, V_LONG[v] != 0, n);
            for (int k = 0; k < 3 * n; k++) begin
                int  idx;
                logic exp_sync;
                idx      = k % n;
                exp_sync = (V_LONG[v] != 0) ? (idx < 3) : (idx == n - 1);
                chk(sync_oe, 1'b1, "R2", "master sync_oe");
                chk(frame_start, idx == 0, "R3", $sformatf("master strobe bit %0d", k));
                chk(sync_out, exp_sync, tag, $sformatf("master sync bit %0d", k));
                if (sync_out) hi_cnt++;
                if (idx == n - 1) begin
                    chk_int(hi_cnt, V_HIGH[v], tag, "sync bits per frame");
                    hi_cnt = 0;
                end
                step;
            end
        end

        // Role switch: master to slave and back
        do_reset(1'b1, 1'b1, 8);
        repeat (5) step;
        is_master = 1'b0;
        step;
        chk(sync_oe, 1'b0, "R2", "oe after switch to slave");
        chk(sync_out, 1'b0, "R2", "sync after switch to slave");
        chk(frame_start, 1'b0, "R2", "strobe after switch to slave");
        is_master = 1'b1;
        step;
        chk(sync_oe, 1'b1, "R2", "oe after switch to master");
        chk(frame_start, 1'b1, "R3", "strobe on master entry");

        // Slave scenarios
        run_slave(1'b0, 8, 40, 5, 99, 0, "R6");
        run_slave(1'b1, 8, 40, 5, 99, 0, "R7");
        run_slave(1'b0, 8, 48, 1, 99, 0, "R8");
        run_slave(1'b1, 8, 48, 1, 99, 0, "R8");
        run_slave(1'b0, 8, 48, 6, 2, 3, "R9");
        run_slave(1'b1, 8, 48, 6, 2, 3, "R9");

        // Stuck-high sync: only the first rise aligns
        do_reset(1'b0, 1'b0, 8);
        for (int g = 0; g < 32; g++) begin
            chk(frame_start, (g > 3) && (((g - 4) % 8) == 0), "R10",
                $sformatf("stuck-high strobe bit %0d", g));
            sync_in = (g >= 3);
            step;
        end
        sync_in = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge bclk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule